// File: doc/BRIEF.md
# Direct-Page Indirect Effective-Address Sequencer

This block works out the operand address for three direct-page indirect addressing forms of an 8/16-bit processor core. When started, it captures an 8-bit instruction offset, the 16-bit direct-page base, the X and Y index registers, the 8-bit data bank value and a mode code. It then forms a pointer location in bank zero and reads the pointer bytes one at a time through a byte-wide memory read port. Finally it merges the pointer with the bank value and, depending on the mode, an index, and reports a 24-bit effective address together with a one-cycle done pulse.

The modes differ in when indexing happens. Two modes index with Y after the pointer has been fetched. One of these joins a 16-bit pointer with the data bank; the other fetches a full 24-bit pointer. The third mode adds X to the pointer location before the fetch and adds no index afterwards. The sequencer is a three-state machine. From ST_IDLE, an accepted start with a legal mode moves to ST_FETCH. ST_FETCH loops once per pointer byte. The valid strobe of the last byte moves it to ST_MERGE, which always returns to ST_IDLE while it registers the result and pulses done. An illegal mode does not leave ST_IDLE: it answers at once with done and an error flag.

Top module: `ind_ea_seq`

## Requirements
- R1: For mode code 2'b00 (pointer then Y) and 2'b01 (long pointer then Y), the pointer location is (offset + dreg) mod 2^16 in bank zero. Pointer byte i is read from address {8'h00, (location + i) mod 2^16}, least significant byte first.
- R2: Mode 2'b00 reads two bytes P and returns ea = ({dbank, P} + yidx) mod 2^24.
- R3: Mode 2'b01 reads three bytes L, ignores dbank, and returns ea = (L + yidx) mod 2^24.
- R4: Mode 2'b10 (X then pointer) uses the location (offset + dreg + xidx) mod 2^16, reads two bytes P and returns ea = {dbank, P}. Y is not added.
- R5: Mode 2'b11 is illegal. done and err are both high in the cycle after the start is taken, ea becomes 0, and no memory request is made.
- R6: mem_req and mem_addr stay unchanged until mem_rvalid is sampled high. Only one request is outstanding at a time, and exactly 2 reads (3 in mode 2'b01) are made per sequence.
- R7: done is a single-cycle pulse, and err is 0 with it for legal modes. ea changes only together with done and holds its value until the next sequence completes.
- R8: Inputs are sampled only when an idle block accepts start. A start, or a change of inputs, while a sequence runs has no effect on its reads or its result.
- R9: After reset, mem_req, done and err are 0 and ea is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode | input | 2 | Addressing form code, see R1 to R5 |
| offset | input | 8 | Instruction offset byte |
| dreg | input | 16 | Direct-page base |
| xidx | input | 16 | X index |
| yidx | input | 16 | Y index |
| dbank | input | 8 | Data bank value |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | 24 | Read byte address |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal mode flag, valid with done |
| ea | output | 24 | Effective address |

## Verification
The embedded assertions check the following on every cycle:
- the request hold rule and the zero bank byte of every read address;
- the single-cycle done pulse and that err never appears without done;
- that ea moves only in a done cycle;
- that no read is ever in flight while done is asserted.

The arithmetic of each mode can only be shown by the bench scenarios, which compare results against independently computed values. The same holds for the wrap of the pointer location and of pointer+i inside bank zero, the discarded carry out of bit 23, the exact read count and order, and the rejection of a start that arrives mid-sequence.

// File: rtl/ind_ea_pkg.sv
package ind_ea_pkg;

    typedef enum logic [1:0] {
        AM_PTR_Y  = 2'b00,
        AM_LONG_Y = 2'b01,
        AM_X_PTR  = 2'b10,
        AM_BAD    = 2'b11
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MERGE = 2'd2
    } seq_st_e;

endpackage

// File: rtl/ind_ptr_addr.sv
module ind_ptr_addr #(
    parameter int OFF_W = 8,
    parameter int PTR_W = 16,
    parameter int IDX_W = 16
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PTR_W-1:0] dreg,
    input  logic [IDX_W-1:0] xidx,
    input  logic             use_x,
    output logic [PTR_W-1:0] loc
);
    logic [PTR_W-1:0] off_ext;
    logic [PTR_W-1:0] x_ext;

    always_comb begin
        off_ext = PTR_W'(offset);
        x_ext   = use_x ? PTR_W'(xidx) : '0;
        loc     = dreg + off_ext + x_ext;
    end
endmodule

// File: rtl/ind_ptr_bytes.sv
module ind_ptr_bytes #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NBYTES*BYTE_W-1:0] ptr_val
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (clr) begin
                b_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                b_q <= wr_data;
            end
        end
        assign ptr_val[g*BYTE_W +: BYTE_W] = b_q;
    end

    // R6
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < NBYTES));
endmodule

// File: rtl/ind_ea_merge.sv
module ind_ea_merge
    import ind_ea_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8,
    parameter int IDX_W  = 16,
    localparam int ADDR_W = PTR_W + BANK_W
) (
    input  am_e               mode,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic [BANK_W-1:0] dbank,
    input  logic [IDX_W-1:0]  yidx,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] banked;
    logic [ADDR_W-1:0] y_ext;

    always_comb begin
        banked = {dbank, ptr_val[PTR_W-1:0]};
        y_ext  = ADDR_W'(yidx);
        unique case (mode)
            AM_PTR_Y:  ea = banked + y_ext;
            AM_LONG_Y: ea = ptr_val + y_ext;
            AM_X_PTR:  ea = banked;
            default:   ea = '0;
        endcase
    end
endmodule

// File: rtl/ind_ea_seq.sv
module ind_ea_seq
    import ind_ea_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8,
    parameter int IDX_W  = 16,
    parameter int BYTE_W = 8,
    localparam int ADDR_W     = PTR_W + BANK_W,
    localparam int SHORT_N    = PTR_W / BYTE_W,
    localparam int LONG_N     = ADDR_W / BYTE_W,
    localparam int CNT_W      = $clog2(LONG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PTR_W-1:0]  dreg,
    input  logic [IDX_W-1:0]  xidx,
    input  logic [IDX_W-1:0]  yidx,
    input  logic [BANK_W-1:0] dbank,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] ea
);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_N - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_N - 1);

    seq_st_e           state_q, state_d;
    am_e               mode_q;
    am_e               mode_in;
    logic [PTR_W-1:0]  loc_d, loc_q;
    logic [IDX_W-1:0]  y_q;
    logic [BANK_W-1:0] bank_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_idx;
    logic              accept;
    logic              bad_mode;
    logic              byte_take;
    logic              last_take;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] ea_calc;
    logic              done_q, err_q;
    logic [ADDR_W-1:0] ea_q;

    assign mode_in   = am_e'(mode);
    assign bad_mode  = (mode_in == AM_BAD);
    assign accept    = (state_q == ST_IDLE) && start;
    assign last_idx  = (mode_q == AM_LONG_Y) ? LAST_LONG : LAST_SHORT;
    assign byte_take = (state_q == ST_FETCH) && mem_rvalid;
    assign last_take = byte_take && (cnt_q == last_idx);

    ind_ptr_addr #(.OFF_W(OFF_W), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_loc (
        .offset (offset),
        .dreg   (dreg),
        .xidx   (xidx),
        .use_x  (mode_in == AM_X_PTR),
        .loc    (loc_d)
    );

    ind_ptr_bytes #(.BYTE_W(BYTE_W), .NBYTES(LONG_N)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .wr_en   (byte_take),
        .wr_idx  (cnt_q),
        .wr_data (mem_rdata),
        .ptr_val (ptr_val)
    );

    ind_ea_merge #(.PTR_W(PTR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_merge (
        .mode    (mode_q),
        .ptr_val (ptr_val),
        .dbank   (bank_q),
        .yidx    (y_q),
        .ea      (ea_calc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && !bad_mode) state_d = ST_FETCH;
            ST_FETCH: if (last_take)          state_d = ST_MERGE;
            ST_MERGE:                         state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= AM_PTR_Y;
            loc_q   <= '0;
            y_q     <= '0;
            bank_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q <= mode_in;
                loc_q  <= loc_d;
                y_q    <= yidx;
                bank_q <= dbank;
                cnt_q  <= '0;
            end else if (byte_take) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            ea_q   <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept && bad_mode) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
                ea_q   <= '0;
            end else if (state_q == ST_MERGE) begin
                done_q <= 1'b1;
                ea_q   <= ea_calc;
            end
        end
    end

    assign mem_req  = (state_q == ST_FETCH);
    assign mem_addr = {{BANK_W{1'b0}}, loc_q + PTR_W'(cnt_q)};
    assign done     = done_q;
    assign err      = err_q;
    assign ea       = ea_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R1
    bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:PTR_W] == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R7
    ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ea) |-> done);

    // R6
    no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && done));
endmodule

// File: tb/ind_ea_seq_bench.sv
module ind_ea_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  offset = '0;
    logic [15:0] dreg = '0, xidx = '0, yidx = '0;
    logic [7:0]  dbank = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        done, err;
    logic [23:0] ea;

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_ea_seq u_ind_ea_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .offset(offset),
        .dreg(dreg), .xidx(xidx), .yidx(yidx), .dbank(dbank),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .done(done), .err(err), .ea(ea)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return ((a[7:0] * 8'd29) ^ a[15:8]) + 8'h3C;
    endfunction

    function automatic logic [15:0] exp_loc(input logic [1:0] m, input logic [7:0] o,
                                            input logic [15:0] d, input logic [15:0] x);
        return d + {8'h00, o} + ((m == 2'b10) ? x : 16'h0000);
    endfunction

    function automatic logic [23:0] exp_ea(input logic [1:0] m, input logic [7:0] o,
                                           input logic [15:0] d, input logic [15:0] x,
                                           input logic [15:0] y, input logic [7:0] b);
        logic [15:0] p;
        logic [23:0] l;
        p = exp_loc(m, o, d, x);
        l = {mem_byte(p + 16'd2), mem_byte(p + 16'd1), mem_byte(p)};
        case (m)
            2'b00:   return {b, l[15:0]} + {8'h00, y};
            2'b01:   return l + {8'h00, y};
            2'b10:   return {b, l[15:0]};
            default: return 24'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] m, input logic [7:0] o, input logic [15:0] d,
                           input logic [15:0] x, input logic [15:0] y, input logic [7:0] b,
                           input bit busy_start);
        logic [23:0] alog [0:7];
        int          nrd;
        bit          seen;
        bit          addr_ok;
        logic [23:0] e_exp, e_hold;
        logic [15:0] p;
        int          want;
        nrd = 0;
        seen = 1'b0;
        @(negedge clk);
        mode = m; offset = o; dreg = d; xidx = x; yidx = y; dbank = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble inputs after acceptance
        offset = 8'($urandom); dreg = 16'($urandom); xidx = 16'($urandom);
        yidx = 16'($urandom); dbank = 8'($urandom);
        for (int it = 0; it < 100; it++) begin
            mem_rvalid = 1'b0;
            if (busy_start && it == 1) begin start = 1'b1; mode = ~m; end
            if (busy_start && it == 2) start = 1'b0;
            if (done) begin seen = 1'b1; break; end
            if (mem_req) begin
                if (lat == 0) begin
                    if (nrd < 8) alog[nrd] = mem_addr;
                    nrd++;
                    mem_rdata = mem_byte(mem_addr[15:0]);
                    mem_rvalid = 1'b1;
                    lat = int'($urandom % 3);
                end else begin
                    lat--;
                end
            end
            @(negedge clk);
        end
        mem_rvalid = 1'b0;
        start = 1'b0;
        check(seen, "R7 done seen (watchdog)", 32'(seen), 1);
        e_exp = exp_ea(m, o, d, x, y, b);
        want = (m == 2'b11) ? 0 : ((m == 2'b01) ? 3 : 2);
        case (m)
            2'b00:   check(ea == e_exp, "R2 ea", ea, e_exp);
            2'b01:   check(ea == e_exp, "R3 ea", ea, e_exp);
            2'b10:   check(ea == e_exp, "R4 ea", ea, e_exp);
            default: check(ea == e_exp, "R5 ea zero", ea, e_exp);
        endcase
        check(err == (m == 2'b11), (m == 2'b11) ? "R5 err" : "R7 err low", 32'(err), 32'(m == 2'b11));
        check(nrd == want, busy_start ? "R8 read count" : "R6 read count", nrd, want);
        p = exp_loc(m, o, d, x);
        addr_ok = 1'b1;
        for (int i = 0; i < nrd && i < 8; i++)
            if (alog[i] != {8'h00, p + 16'(i)}) addr_ok = 1'b0;
        if (nrd > 0)
            check(addr_ok, (m == 2'b10) ? "R4 read addresses" : "R1 read addresses",
                  (nrd > 0) ? alog[0] : 0, {8'h00, p});
        e_hold = ea;
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", 32'(done), 0);
        repeat (2) @(negedge clk);
        check(ea == e_hold, "R7 ea held", ea, e_hold);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9
        check(mem_req == 1'b0, "R9 reset mem_req", 32'(mem_req), 0);
        check(done == 1'b0 && err == 1'b0, "R9 reset done/err", {30'h0, done, err}, 0);
        check(ea == 24'h0, "R9 reset ea", ea, 0);
        rst_n = 1'b1;
        // directed corners
        run_txn(2'b00, 8'h20, 16'hFFF0, 16'h1111, 16'h0003, 8'h12, 1'b0); // R1 location wrap
        run_txn(2'b00, 8'h0F, 16'hFFF0, 16'h0000, 16'hFFFF, 8'hFF, 1'b0); // R1 pointer+1 wrap, R2 carry drop
        run_txn(2'b01, 8'h00, 16'hFFFE, 16'h0000, 16'hFFFF, 8'hAA, 1'b0); // R3 long wrap and carry
        run_txn(2'b10, 8'h80, 16'hFF00, 16'h0090, 16'hFFFF, 8'h34, 1'b0); // R4 X wrap, no Y
        run_txn(2'b11, 8'h10, 16'h2000, 16'h0001, 16'h0002, 8'h56, 1'b0); // R5 illegal
        run_txn(2'b00, 8'h44, 16'h1200, 16'h0000, 16'h0100, 8'h07, 1'b1); // R8 busy start
        run_txn(2'b01, 8'h44, 16'h1200, 16'h0000, 16'h0100, 8'h07, 1'b1); // R8 busy start long
        // constrained random
        for (int k = 0; k < 40; k++) begin
            logic [1:0] rm;
            rm = 2'($urandom % 3);
            if (k % 13 == 12) rm = 2'b11;
            run_txn(rm, 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                    8'($urandom), (k % 5) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule